// File: doc/BRIEF.md
# Seven-Lane Edge-Pattern Phase Detector with Margin Voter

This block looks at one reference clock period of a seven-bit serial word and decides whether the data delay should move. Each of the seven bit slots supplies three samples: early, center and late. The three samples come from copies of the data stream delayed by different amounts, all captured by the same clock phase. Seven identical pattern classifiers check each slot's triplet for a transition. A transition between the early and center samples means the edge came before the center sample, so the slot requests an up move (more delay). A transition between the center and late samples means the edge came after the center sample, so the slot requests a down move (less delay).

The voter counts the up and down requests from the seven slots. It registers a single verdict per reference clock. A verdict is issued only when one direction leads the other by at least two requests, so an isolated jitter hit cannot tip the result. The verdict is held in a three-state register: `V_HOLD`, `V_UP` or `V_DOWN`. On every clock the register moves to `V_UP` when the up margin is met, to `V_DOWN` when the down margin is met, and otherwise to `V_HOLD`. Any state can reach any other state in one clock, and the register keeps no history beyond the last period. Filtering over several periods is left to a later stage.

Top module: `edge_vote_top`

## Requirements
- R1: A slot whose triplet (early, center, late) is 100 or 011 raises an up request.
- R2: A slot whose triplet is 001 or 110 raises a down request.
- R3: Triplets 000, 111, 010 and 101 raise no request, so they add nothing to either count.
- R4: `vote_up` is high in the cycle after a clock edge exactly when, at that edge, the up count is at least the down count plus two.
- R5: `vote_dn` is high in the cycle after a clock edge exactly when, at that edge, the down count is at least the up count plus two.
- R6: When one direction leads the other by exactly one request, both outputs are low in the following cycle.
- R7: `vote_up` and `vote_dn` are never high together.
- R8: When `rst` is high at a clock edge, both outputs are low after that edge, whatever the samples are.
- R9: Each verdict depends only on the samples at the most recent edge. A strong request in one period leaves no trace in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one word period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_early | input | 7 | Early sample of each slot, bit i is slot i |
| smp_center | input | 7 | Center sample of each slot |
| smp_late | input | 7 | Late sample of each slot |
| vote_up | output | 1 | Registered verdict: increase data delay |
| vote_dn | output | 1 | Registered verdict: decrease data delay |

## Verification
The properties assume that the three sample vectors are already synchronized, free of X, and stable around each rising clock edge. The synchronizer in front of this block is what provides that. They also assume that every 21-bit combination is a legal input. The bench keeps to these assumptions by changing all samples only on the falling edge. It draws random words from the full input space and adds directed words built to hit exact up-versus-down differences of zero, one and two. The properties relate the internal request counts to the next-cycle verdict, so the bench must drive word mixes where the two counts sit close together, and not only words with all slots pointing one way.

// File: rtl/dpv_pkg.sv
package dpv_pkg;

    // Verdict register encoding
    typedef enum logic [1:0] {
        V_HOLD = 2'd0,
        V_UP   = 2'd1,
        V_DOWN = 2'd2
    } vote_state_t;

    // Request produced by one slot classifier
    typedef struct packed {
        logic up;
        logic dn;
    } slot_req_t;

endpackage

// File: rtl/edge_pattern_classify.sv
module edge_pattern_classify
    import dpv_pkg::*;
(
    input  logic      early_i,
    input  logic      center_i,
    input  logic      late_i,
    output slot_req_t req_o
);

    always_comb begin
        req_o = '0;
        unique case ({early_i, center_i, late_i})
            // edge before center sample: data arrives early, add delay
            3'b100, 3'b011: req_o.up = 1'b1;
            // edge after center sample: data arrives late, remove delay
            3'b001, 3'b110: req_o.dn = 1'b1;
            // flat or non-monotonic triplets carry no usable phase information
            default: req_o = '0;
        endcase
    end

endmodule

// File: rtl/request_tally.sv
module request_tally #(
    parameter int LANES = 7,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] up_req_i,
    input  logic [LANES-1:0] dn_req_i,
    output logic [CW-1:0]    up_cnt_o,
    output logic [CW-1:0]    dn_cnt_o
);

    always_comb begin
        up_cnt_o = '0;
        dn_cnt_o = '0;
        for (int i = 0; i < LANES; i++) begin
            up_cnt_o = up_cnt_o + CW'(up_req_i[i]);
            dn_cnt_o = dn_cnt_o + CW'(dn_req_i[i]);
        end
    end

endmodule

// File: rtl/vote_fsm.sv
module vote_fsm
    import dpv_pkg::*;
#(
    parameter int CW     = 3,
    parameter int MARGIN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] up_cnt_i,
    input  logic [CW-1:0] dn_cnt_i,
    output logic          vote_up_o,
    output logic          vote_dn_o
);

    localparam int SW = CW + 1;

    vote_state_t state_q, state_d;
    logic [SW-1:0] up_ext, dn_ext;
    logic          up_win, dn_win;

    assign up_ext = {1'b0, up_cnt_i};
    assign dn_ext = {1'b0, dn_cnt_i};
    assign up_win = up_ext >= (dn_ext + SW'(MARGIN));
    assign dn_win = dn_ext >= (up_ext + SW'(MARGIN));

    // Transition selection: every state may go to any state in one period
    always_comb begin
        if (up_win)      state_d = V_UP;
        else if (dn_win) state_d = V_DOWN;
        else             state_d = V_HOLD;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= V_HOLD;
        else     state_q <= state_d;
    end

    // Output decode
    always_comb begin
        vote_up_o = 1'b0;
        vote_dn_o = 1'b0;
        unique case (state_q)
            V_UP:    vote_up_o = 1'b1;
            V_DOWN:  vote_dn_o = 1'b1;
            V_HOLD:  ;
            default: ;
        endcase
    end

endmodule

// File: rtl/edge_vote_top.sv
module edge_vote_top
    import dpv_pkg::*;
#(
    parameter int LANES  = 7,
    parameter int MARGIN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] smp_early,
    input  logic [LANES-1:0] smp_center,
    input  logic [LANES-1:0] smp_late,
    output logic             vote_up,
    output logic             vote_dn
);

    localparam int CW = $clog2(LANES + 1);

    logic [LANES-1:0] up_req, dn_req;
    logic [CW-1:0]    up_cnt, dn_cnt;

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        slot_req_t r;
        edge_pattern_classify u_cls (
            .early_i  (smp_early[g]),
            .center_i (smp_center[g]),
            .late_i   (smp_late[g]),
            .req_o    (r)
        );
        assign up_req[g] = r.up;
        assign dn_req[g] = r.dn;
    end

    request_tally #(.LANES(LANES), .CW(CW)) u_tally (
        .up_req_i (up_req),
        .dn_req_i (dn_req),
        .up_cnt_o (up_cnt),
        .dn_cnt_o (dn_cnt)
    );

    vote_fsm #(.CW(CW), .MARGIN(MARGIN)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .up_cnt_i  (up_cnt),
        .dn_cnt_i  (dn_cnt),
        .vote_up_o (vote_up),
        .vote_dn_o (vote_dn)
    );

endmodule

// File: rtl/edge_vote_checker.sv
module edge_vote_checker #(
    parameter int LANES = 7,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] up_req,
    input logic [LANES-1:0] dn_req,
    input logic [CW-1:0]    up_cnt,
    input logic [CW-1:0]    dn_cnt,
    input logic             vote_up,
    input logic             vote_dn
);

    int u, d;
    assign u = int'(up_cnt);
    assign d = int'(dn_cnt);

    // R1 R2 R3: a slot never asks for both directions
    p_slot_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(up_req & dn_req) == 0);

    p_count_up_r1: assert property (@(posedge clk) disable iff (rst)
        u == $countones(up_req));

    p_up_margin_r4: assert property (@(posedge clk) disable iff (rst)
        (u >= d + 2) |=> vote_up);

    p_up_only_r4: assert property (@(posedge clk) disable iff (rst)
        (u < d + 2) |=> !vote_up);

    p_dn_margin_r5: assert property (@(posedge clk) disable iff (rst)
        (d >= u + 2) |=> vote_dn);

    p_one_lead_r6: assert property (@(posedge clk) disable iff (rst)
        ((u == d + 1) || (d == u + 1)) |=> (!vote_up && !vote_dn));

    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(vote_up && vote_dn));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!vote_up && !vote_dn));

    p_no_memory_r9: assert property (@(posedge clk) disable iff (rst)
        (u == 0 && d == 0) |=> (!vote_up && !vote_dn));

endmodule

bind edge_vote_top edge_vote_checker #(.LANES(LANES), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .up_req  (up_req),
    .dn_req  (dn_req),
    .up_cnt  (up_cnt),
    .dn_cnt  (dn_cnt),
    .vote_up (vote_up),
    .vote_dn (vote_dn)
);

// File: tb/edge_vote_top_test.sv
`timescale 1ns/1ps
module edge_vote_top_test;

    localparam int LANES = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] smp_early  = '0;
    logic [LANES-1:0] smp_center = '0;
    logic [LANES-1:0] smp_late   = '0;
    logic             vote_up, vote_dn;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    edge_vote_top uut (
        .clk        (clk),
        .rst        (rst),
        .smp_early  (smp_early),
        .smp_center (smp_center),
        .smp_late   (smp_late),
        .vote_up    (vote_up),
        .vote_dn    (vote_dn)
    );

    // slot i triplet = w[3*i +: 3], bit2 early, bit1 center, bit0 late
    function automatic int slot_dir(input logic [2:0] t);
        if (t == 3'b100 || t == 3'b011) return 1;
        if (t == 3'b001 || t == 3'b110) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] expect_vote(input logic [3*LANES-1:0] w);
        int nu = 0, nd = 0;
        for (int i = 0; i < LANES; i++) begin
            int s = slot_dir(w[3*i +: 3]);
            if (s > 0) nu++;
            if (s < 0) nd++;
        end
        return {nu >= nd + 2, nd >= nu + 2};
    endfunction

    function automatic string tag_of(input logic [3*LANES-1:0] w);
        int nu = 0, nd = 0;
        for (int i = 0; i < LANES; i++) begin
            int s = slot_dir(w[3*i +: 3]);
            if (s > 0) nu++;
            if (s < 0) nd++;
        end
        if (nu >= nd + 2) return "R4";
        if (nd >= nu + 2) return "R5";
        if (nu == nd + 1 || nd == nu + 1) return "R6";
        return "R9";
    endfunction

    task automatic drive(input logic [3*LANES-1:0] w);
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            smp_early[i]  = w[3*i + 2];
            smp_center[i] = w[3*i + 1];
            smp_late[i]   = w[3*i];
        end
    endtask

    task automatic compare(input logic [1:0] exp, input string tag);
        checks++;
        if ({vote_up, vote_dn} !== exp) begin
            errors++;
            $display("FAIL %s: up/dn actual %b%b expected %b%b", tag, vote_up, vote_dn, exp[1], exp[0]);
        end
        checks++;
        if (vote_up && vote_dn) begin
            errors++;
            $display("FAIL R7: up/dn actual 11 expected not both high");
        end
    endtask

    task automatic step(input logic [3*LANES-1:0] w, input string tag);
        drive(w);
        @(posedge clk);
        #1;
        compare(expect_vote(w), tag);
    endtask

    // replicate one triplet on the given number of low slots, rest 000
    function automatic logic [3*LANES-1:0] fill(input logic [2:0] t, input int n);
        logic [3*LANES-1:0] w = '0;
        for (int i = 0; i < n; i++) w[3*i +: 3] = t;
        return w;
    endfunction

    function automatic logic [3*LANES-1:0] mix(input int nu, input int nd);
        logic [3*LANES-1:0] w = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < nu)           w[3*i +: 3] = (i % 2) ? 3'b011 : 3'b100;
            else if (i < nu + nd) w[3*i +: 3] = (i % 2) ? 3'b110 : 3'b001;
            else                  w[3*i +: 3] = (i % 2) ? 3'b111 : 3'b010;
        end
        return w;
    endfunction

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        // R8: reset state with strong up stimulus
        drive(fill(3'b100, 7));
        @(posedge clk); @(posedge clk); #1;
        compare(2'b00, "R8");
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        compare(2'b10, "R4");

        // R1 R2 R3: every triplet on two slots
        step(fill(3'b100, 2), "R1");
        step(fill(3'b011, 2), "R1");
        step(fill(3'b001, 2), "R2");
        step(fill(3'b110, 2), "R2");
        step(fill(3'b000, 2), "R3");
        step(fill(3'b111, 2), "R3");
        step(fill(3'b010, 2), "R3");
        step(fill(3'b101, 7), "R3");

        // R6: lead of one in either direction
        step(mix(1, 0), "R6");
        step(mix(0, 1), "R6");
        step(mix(4, 3), "R6");
        step(mix(3, 4), "R6");
        // R4 R5 margin boundaries
        step(mix(4, 2), "R4");
        step(mix(2, 4), "R5");
        step(mix(7, 0), "R4");
        step(mix(0, 7), "R5");
        step(mix(3, 3), "R9");
        // R9: strong period followed by empty period
        step(mix(0, 6), "R5");
        step(mix(0, 0), "R9");

        // R8: mid-run reset overrides a strong down
        drive(mix(0, 7));
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        compare(2'b00, "R8");
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        compare(2'b01, "R5");

        // random words, biased toward close counts half the time
        for (int k = 0; k < 400; k++) begin
            logic [3*LANES-1:0] w;
            if (k % 2 == 0) w = 21'($urandom());
            else            w = mix(int'($urandom_range(0, 4)), int'($urandom_range(0, 3)));
            step(w, tag_of(w));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule